// File: doc/BRIEF.md
# Selectable-Topology Pseudorandom Shift Register

This block is an N-bit linear feedback shift register that produces one pseudorandom state word and one serial bit per enabled clock. One parameter picks where the exclusive-OR gates sit. In the external form, a parity tree combines the tapped bits and feeds only stage 0. In the internal form, the most significant bit is folded into each tapped stage as the word shifts. Both forms are built from the same tap mask, so for a maximal mask they walk through the same set of states, each in its own order.

Two further parameters choose the feedback polarity and the cycle length. With inverted polarity, the stuck state becomes all-ones instead of all-zeros. With the extended cycle, a detector on the lower N-1 bits flips the feedback, so the stuck state is spliced into the sequence and the period grows from 2^N-1 to 2^N. A seed can be loaded at any time. When the cycle is not extended, a seed equal to the stuck state is replaced by a safe value.

Top module: `prng_lfsr`

## Requirements
- R1: After synchronous reset, `state` is the safe value: 0x01 (bit 0 set, all others clear) with normal polarity, and all-ones except bit 0 (0xFE at N=8) with inverted polarity.
- R2: When `load` and `en` are both low, `state` holds its value through the clock edge.
- R3: When `load` is high, `state` takes `seed` on that edge, whatever the value of `en`. A load takes priority over a step.
- R4: When the cycle is not extended, a `seed` equal to the stuck state (all-zeros for normal polarity, all-ones for inverted) loads the safe value of R1 instead. When the cycle is extended, every seed loads unchanged.
- R5: In the external form, a step moves `state[N-2:0]` up into `state[N-1:1]`. The new bit 0 is the parity of `state & TAPS`, inverted under inverted polarity, so only one new bit enters per clock. At N=8 with TAPS=0xB8, 0x01 steps to 0x02 and 0x80 steps to 0x01.
- R6: In the internal form, a step moves the MSB into bit 0 and XORs it into every bit i>=1 for which `TAPS[i-1]` is set. At N=8 with TAPS=0xB8 and normal polarity, 0x80 steps to 0x71.
- R7: When the cycle is not extended, the stuck state is never entered. Under inverted polarity at N=8 with TAPS=0xB8 in the external form, 0x7F steps to 0xFE and then to 0xFD.
- R8: When the cycle is not extended and the tap mask is maximal, the sequence returns to its start after exactly 2^N-1 steps and visits 2^N-1 distinct states.
- R9: When the cycle is extended, the stuck state is spliced in: the period is exactly 2^N. In the external form with normal polarity, 0x80 steps to 0x00 and then to 0x01. In the internal form with inverted polarity, 0x7F steps to 0xFF and then to 0x8E.
- R10: With the same tap mask and polarity, the external and internal forms visit identical sets of states.
- R11: `bit_out` always equals `state[N-1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the register by one step |
| load | input | 1 | Replace the state with the seed (overrides `en`) |
| seed | input | N | Seed value to load |
| state | output | N | Current register contents |
| bit_out | output | 1 | Serial output, the most significant state bit |

## Verification
The in-line assertions check the local rules on every cycle: hold when idle, seed capture and seed substitution, the one-bit shift of the external form, the MSB landing in bit 0 of the internal form, the stuck state never appearing when the cycle is not extended, and the stuck state never repeating when it is. Global properties cannot be seen one cycle at a time, so only the bench's sweeps show them. These are the exact period of 255 or 256, the count of distinct states, and the equality of the state sets of the two forms. The bench also checks hand-computed single steps at the splice points of the extended cycle.

// File: rtl/prng_pkg.sv
package prng_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2
    } prng_op_e;

    typedef struct packed {
        logic load;
        logic en;
    } prng_ctl_t;

    // load wins over a step
    function automatic prng_op_e decode_op(input prng_ctl_t ctl);
        if (ctl.load)
            return OP_LOAD;
        else if (ctl.en)
            return OP_STEP;
        else
            return OP_HOLD;
    endfunction

    function automatic logic polarity(input int inv_fb);
        return (inv_fb != 0);
    endfunction

endpackage

// File: rtl/prng_lockmark.sv
// Flags the two states whose low N-1 bits match the stuck pattern; only
// active when the extended cycle is selected.
module prng_lockmark #(
    parameter int N           = 8,
    parameter int XNOR_FB     = 0,
    parameter int FULL_PERIOD = 0
) (
    input  logic [N-2:0] low_bits,
    output logic         mark
);
    import prng_pkg::*;

    localparam logic POL = polarity(XNOR_FB);

    logic low_match;

    always_comb begin
        if (POL)
            low_match = &low_bits;
        else
            low_match = ~|low_bits;
        mark = (FULL_PERIOD != 0) && low_match;
    end

endmodule

// File: rtl/prng_seed_guard.sv
// Replaces a seed equal to the stuck state when the short cycle is in use.
module prng_seed_guard #(
    parameter int N           = 8,
    parameter int XNOR_FB     = 0,
    parameter int FULL_PERIOD = 0
) (
    input  logic [N-1:0] seed_in,
    output logic [N-1:0] seed_out
);
    import prng_pkg::*;

    localparam logic         POL  = polarity(XNOR_FB);
    localparam logic [N-1:0] LOCK = {N{POL}};
    localparam logic [N-1:0] SAFE = {{(N-1){POL}}, ~POL};

    always_comb begin
        if (FULL_PERIOD == 0 && seed_in == LOCK)
            seed_out = SAFE;
        else
            seed_out = seed_in;
    end

endmodule

// File: rtl/prng_step_ext.sv
// External-feedback step: parity of the tapped bits enters at stage 0.
module prng_step_ext #(
    parameter int           N       = 8,
    parameter logic [N-1:0] TAPS    = 'hB8,
    parameter int           XNOR_FB = 0
) (
    input  logic [N-1:0] cur,
    input  logic         mark,
    output logic [N-1:0] nxt
);
    import prng_pkg::*;

    localparam logic POL = polarity(XNOR_FB);

    logic fb;

    always_comb begin
        fb  = (^(cur & TAPS)) ^ POL ^ mark;
        nxt = {cur[N-2:0], fb};
    end

endmodule

// File: rtl/prng_step_int.sv
// Internal-feedback step: the MSB is folded into each tapped stage.
module prng_step_int #(
    parameter int           N       = 8,
    parameter logic [N-1:0] TAPS    = 'hB8,
    parameter int           XNOR_FB = 0
) (
    input  logic [N-1:0] cur,
    input  logic         mark,
    output logic [N-1:0] nxt
);
    import prng_pkg::*;

    localparam logic POL = polarity(XNOR_FB);

    logic inj;

    assign inj    = cur[N-1] ^ POL ^ mark;
    assign nxt[0] = inj ^ POL;

    generate
        for (genvar i = 1; i < N; i++) begin : g_stage
            if (TAPS[i-1]) begin : g_tap
                assign nxt[i] = cur[i-1] ^ inj;
            end else begin : g_plain
                assign nxt[i] = cur[i-1];
            end
        end
    endgenerate

endmodule

// File: rtl/prng_lfsr.sv
module prng_lfsr #(
    parameter int           N           = 8,
    parameter logic [N-1:0] TAPS        = 'hB8,
    parameter int           TYPE2       = 0,
    parameter int           XNOR_FB     = 0,
    parameter int           FULL_PERIOD = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         load,
    input  logic [N-1:0] seed,
    output logic [N-1:0] state,
    output logic         bit_out
);
    import prng_pkg::*;

    localparam logic         POL  = polarity(XNOR_FB);
    localparam logic [N-1:0] LOCK = {N{POL}};
    localparam logic [N-1:0] SAFE = {{(N-1){POL}}, ~POL};
    localparam logic [N-1:0] PRE  = {~POL, {(N-1){POL}}};

    logic [N-1:0] state_q;
    logic [N-1:0] seed_safe;
    logic [N-1:0] step_nxt;
    logic         mark;
    prng_ctl_t    ctl;

    assign ctl.load = load;
    assign ctl.en   = en;

    prng_lockmark #(.N(N), .XNOR_FB(XNOR_FB), .FULL_PERIOD(FULL_PERIOD)) u_mark (
        .low_bits (state_q[N-2:0]),
        .mark     (mark)
    );

    prng_seed_guard #(.N(N), .XNOR_FB(XNOR_FB), .FULL_PERIOD(FULL_PERIOD)) u_guard (
        .seed_in  (seed),
        .seed_out (seed_safe)
    );

    generate
        if (TYPE2 != 0) begin : g_internal
            prng_step_int #(.N(N), .TAPS(TAPS), .XNOR_FB(XNOR_FB)) u_step (
                .cur  (state_q),
                .mark (mark),
                .nxt  (step_nxt)
            );
        end else begin : g_external
            prng_step_ext #(.N(N), .TAPS(TAPS), .XNOR_FB(XNOR_FB)) u_step (
                .cur  (state_q),
                .mark (mark),
                .nxt  (step_nxt)
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SAFE;
        end else begin
            case (decode_op(ctl))
                OP_LOAD: state_q <= seed_safe;
                OP_STEP: state_q <= step_nxt;
                default: state_q <= state_q;
            endcase
        end
    end

    assign state   = state_q;
    assign bit_out = state_q[N-1];

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !load) |=> $stable(state));

    // R3
    seed_take_chk: assert property (@(posedge clk) disable iff (rst)
        (load && (FULL_PERIOD != 0 || seed != LOCK)) |=> (state == $past(seed)));

    generate
        if (FULL_PERIOD == 0) begin : g_short_chk
            // R4
            seed_sub_chk: assert property (@(posedge clk) disable iff (rst)
                (load && seed == LOCK) |=> (state == SAFE));
            // R7
            lock_avoid_chk: assert property (@(posedge clk) disable iff (rst)
                state != LOCK);
        end else begin : g_full_chk
            // R9
            lock_leave_chk: assert property (@(posedge clk) disable iff (rst)
                (en && !load && state == LOCK) |=> (state != LOCK));
            if (TYPE2 == 0) begin : g_ext_splice
                // R9
                splice_in_chk: assert property (@(posedge clk) disable iff (rst)
                    (en && !load && state == PRE) |=> (state == LOCK));
            end
        end
        if (TYPE2 == 0) begin : g_ext_chk
            // R5
            shift_copy_chk: assert property (@(posedge clk) disable iff (rst)
                (en && !load) |=> (state[N-1:1] == $past(state[N-2:0])));
        end else if (FULL_PERIOD == 0 && XNOR_FB == 0) begin : g_int_chk
            // R6
            msb_wrap_chk: assert property (@(posedge clk) disable iff (rst)
                (en && !load) |=> (state[0] == $past(state[N-1])));
        end
    endgenerate

endmodule

// File: tb/prng_lfsr_tb_top.sv
module prng_lfsr_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       load = 1'b0;
    logic [7:0] seed = 8'h00;

    logic [7:0] sA, sB, sC, sD, sE;
    logic       bA, bB, bC, bD, bE;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int unsigned cyc = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    // A: external, normal, short
    prng_lfsr #(.N(8), .TAPS(8'hB8), .TYPE2(0), .XNOR_FB(0), .FULL_PERIOD(0)) dut_i (
        .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed), .state(sA), .bit_out(bA));
    // B: internal, normal, short
    prng_lfsr #(.N(8), .TAPS(8'hB8), .TYPE2(1), .XNOR_FB(0), .FULL_PERIOD(0)) dut_b (
        .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed), .state(sB), .bit_out(bB));
    // C: external, normal, extended
    prng_lfsr #(.N(8), .TAPS(8'hB8), .TYPE2(0), .XNOR_FB(0), .FULL_PERIOD(1)) dut_c (
        .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed), .state(sC), .bit_out(bC));
    // D: internal, inverted, extended
    prng_lfsr #(.N(8), .TAPS(8'hB8), .TYPE2(1), .XNOR_FB(1), .FULL_PERIOD(1)) dut_d (
        .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed), .state(sD), .bit_out(bD));
    // E: external, inverted, short
    prng_lfsr #(.N(8), .TAPS(8'hB8), .TYPE2(0), .XNOR_FB(1), .FULL_PERIOD(0)) dut_e (
        .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed), .state(sE), .bit_out(bE));

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            finish_run();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(input logic [7:0] v, input logic with_en);
        seed = v; load = 1'b1; en = with_en;
        step();
        load = 1'b0; en = 1'b0;
    endtask

    initial begin
        logic [255:0] visA, visB, visC, visD, visE;
        logic [7:0]   prevA;
        int           perA, perB, perC, perD, perE;
        int           shift_bad, bit_bad;

        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset values
        chk("R1 normal", int'(sA), 8'h01);
        chk("R1 inverted", int'(sE), 8'hFE);

        // R2 hold with en low
        repeat (3) step();
        chk("R2 hold", int'(sA), 8'h01);

        // R3 load with and without en
        do_load(8'h5A, 1'b0);
        chk("R3 load idle", int'(sA), 8'h5A);
        do_load(8'h3C, 1'b1);
        chk("R3 load over step", int'(sA), 8'h3C);

        // R5 / R6 single steps
        do_load(8'h01, 1'b0);
        en = 1'b1; step(); en = 1'b0;
        chk("R5 ext 01->02", int'(sA), 8'h02);
        do_load(8'h80, 1'b0);
        en = 1'b1; step(); en = 1'b0;
        chk("R5 ext 80->01", int'(sA), 8'h01);
        chk("R6 int 80->71", int'(sB), 8'h71);
        chk("R9 ext full 80->00", int'(sC), 8'h00);
        en = 1'b1; step(); en = 1'b0;
        chk("R9 ext full 00->01", int'(sC), 8'h01);

        // R4 stuck-state seeds
        do_load(8'h00, 1'b0);
        chk("R4 sub normal", int'(sA), 8'h01);
        chk("R4 sub internal", int'(sB), 8'h01);
        chk("R4 full verbatim", int'(sC), 8'h00);
        do_load(8'hFF, 1'b0);
        chk("R4 sub inverted", int'(sE), 8'hFE);
        chk("R4 full inverted verbatim", int'(sD), 8'hFF);

        // R7 inverted short walk and R9 inverted internal splice
        do_load(8'h7F, 1'b0);
        en = 1'b1; step();
        chk("R7 inv 7F->FE", int'(sE), 8'hFE);
        chk("R9 int inv 7F->FF", int'(sD), 8'hFF);
        step(); en = 1'b0;
        chk("R7 inv FE->FD", int'(sE), 8'hFD);
        chk("R9 int inv FF->8E", int'(sD), 8'h8E);

        // R8 R9 R10 R11 sweep
        do_load(8'h01, 1'b0);
        visA = '0; visB = '0; visC = '0; visD = '0; visE = '0;
        perA = 0; perB = 0; perC = 0; perD = 0; perE = 0;
        shift_bad = 0; bit_bad = 0;
        en = 1'b1;
        for (int k = 1; k <= 256; k++) begin
            prevA = sA;
            step();
            if (sA[7:1] != prevA[6:0]) shift_bad++;
            if (bA != sA[7] || bB != sB[7] || bC != sC[7] || bD != sD[7] || bE != sE[7])
                bit_bad++;
            visA[sA] = 1'b1; visB[sB] = 1'b1; visC[sC] = 1'b1;
            visD[sD] = 1'b1; visE[sE] = 1'b1;
            if (perA == 0 && sA == 8'h01) perA = k;
            if (perB == 0 && sB == 8'h01) perB = k;
            if (perC == 0 && sC == 8'h01) perC = k;
            if (perD == 0 && sD == 8'h01) perD = k;
            if (perE == 0 && sE == 8'h01) perE = k;
        end
        en = 1'b0;
        chk("R8 period ext", perA, 255);
        chk("R8 period int", perB, 255);
        chk("R8 period inv", perE, 255);
        chk("R8 distinct ext", $countones(visA), 255);
        chk("R7 zero never ext", int'(visA[0]), 0);
        chk("R7 zero never int", int'(visB[0]), 0);
        chk("R7 ones never inv", int'(visE[255]), 0);
        chk("R9 period ext full", perC, 256);
        chk("R9 period int inv full", perD, 256);
        chk("R9 distinct full", $countones(visC) + $countones(visD), 512);
        chk("R10 same set", int'(visA == visB), 1);
        chk("R5 shift copies", shift_bad, 0);
        chk("R11 bit_out msb", bit_bad, 0);

        done = 1'b1;
        finish_run();
    end

endmodule